// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block holds the interrupt state behind a register window. Four event sources (data available, status valid, locality change and command ready) each deliver one-cycle pulses. Each pulse sets a sticky bit in a status register. Software reads that register to find the pending causes and clears the ones it has handled by writing 1s to them. A status value of zero means nothing is pending.

An enable register holds one enable per source plus a global enable in bit 31. The interrupt output is raised when the global enable is set and at least one pending status bit has its enable set. A vector register stores the interrupt line number chosen by software and drives it out as `irq_line`. A read-only capability word reports which sources exist, which signalling mode this instance was built for, and whether the burst count is static. The signalling mode is a build-time parameter: active-high level, active-low level, a rising-edge pulse or a falling-edge pulse.

Register access is a simple word port with one-cycle read latency. Bus decode and the logic that produces the events are outside this block.

Top module: `evirq_ctrl`

## Requirements
- R1: After reset, the enable, status and vector registers read 0, `irq_line` is 0 and `irq_o` is at its idle level (0 for the default level-high mode).
- R2: A pulse on a source input sets its status bit one clock later, whether or not that source is enabled. The bit positions are data available 0, status valid 1, locality change 2 and command ready 7. A set bit stays set until it is cleared.
- R3: A write to the status register (offset 0x010) clears every status bit whose position is 1 in the written value. Bits written as 0 and positions that have no source are not affected.
- R4: If an event arrives in the same cycle as a write that clears its bit, the event wins and the bit stays set.
- R5: The enable register (offset 0x008) keeps bits 0, 1, 2, 7 and bit 31 (global enable). All its other bits read 0.
- R6: In the default level-high mode, `irq_o` is 1 exactly one clock after a cycle in which the global enable is set and the status AND enable value is non-zero. Otherwise it is 0.
- R7: The vector register (offset 0x00C) keeps only the low 4 bits of a write. It reads back with its upper bits at 0 and drives `irq_line`.
- R8: The capability register (offset 0x014) reads 0x0000018F with default parameters. Bits 0, 1, 2 and 7 mark the sources. One of bits 3 to 6 marks the configured mode (3 level-high, 4 level-low, 5 rising, 6 falling). Bit 8 marks a static burst count. Writes to this register have no effect.
- R9: Read data appears on `reg_rdata` one clock after `reg_rd`. An offset that maps to no register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ev_data_avail | input | 1 | Data-available event pulse |
| ev_sts_valid | input | 1 | Status-valid event pulse |
| ev_loc_change | input | 1 | Locality-change event pulse |
| ev_cmd_ready | input | 1 | Command-ready event pulse |
| irq_o | output | 1 | Interrupt output, registered |
| irq_line | output | VEC_W | Stored interrupt line number |

## Verification
Each result has a fixed latency:
- A status bit changes one clock after its event pulse or clearing write.
- Read data is due one clock after the read strobe.
- `irq_o` moves one clock after the status or enable change that causes it, so an event reaches `irq_o` after two edges.

The bench drives inputs on falling edges and samples on the next falling edge for register values. It checks `irq_o` twice: once at the falling edge where it must not have moved yet, and again one edge later. This confirms both the value and the cycle in which it appears.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  localparam int NSRC = 4;
  localparam int REG_W = 32;
  localparam int GIE_BIT = 31;
  localparam int CAP_MODE_LSB = 3;
  localparam int CAP_BURST_BIT = 8;

  localparam logic [11:0] OFF_EN   = 12'h008;
  localparam logic [11:0] OFF_VEC  = 12'h00C;
  localparam logic [11:0] OFF_STAT = 12'h010;
  localparam logic [11:0] OFF_CAP  = 12'h014;

  typedef enum logic [1:0] {
    POL_LEVEL_HIGH = 2'd0,
    POL_LEVEL_LOW  = 2'd1,
    POL_EDGE_RISE  = 2'd2,
    POL_EDGE_FALL  = 2'd3
  } pol_e;

  // source index -> register bit position
  function automatic int src_pos(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 7;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] src_word_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/evirq_status.sv
module evirq_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ev[i])                        stat_q[i] <= 1'b1;  // set beats clear
        else if (clr_we && clr_bits[i])   stat_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evirq_cfg.sv
module evirq_cfg #(
  parameter int N     = 4,
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic [N-1:0]     en_bits,
  input  logic             gie_bit,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_bits,
  output logic [N-1:0]     en_q,
  output logic             gie_q,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      gie_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (en_we) begin
        en_q  <= en_bits;
        gie_q <= gie_bit;
      end
      if (vec_we) vec_q <= vec_bits;
    end
  end
endmodule

// File: rtl/evirq_out.sv
module evirq_out
  import evirq_pkg::*;
#(
  parameter pol_e POL = POL_LEVEL_HIGH
) (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  output logic irq_o
);
  localparam logic IDLE = (POL == POL_LEVEL_LOW) || (POL == POL_EDGE_FALL);

  logic pend_d;
  logic nxt;

  always_comb begin
    case (POL)
      POL_LEVEL_HIGH: nxt = pend;
      POL_LEVEL_LOW:  nxt = ~pend;
      POL_EDGE_RISE:  nxt = pend & ~pend_d;
      default:        nxt = ~(pend & ~pend_d);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_d <= 1'b0;
      irq_o  <= IDLE;
    end else begin
      pend_d <= pend;
      irq_o  <= nxt;
    end
  end
endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl
  import evirq_pkg::*;
#(
  parameter int   ADDR_W       = 12,
  parameter int   VEC_W        = 4,
  parameter pol_e POLARITY     = POL_LEVEL_HIGH,
  parameter bit   BURST_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_data_avail,
  input  logic              ev_sts_valid,
  input  logic              ev_loc_change,
  input  logic              ev_cmd_ready,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_line
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFF_VEC);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(OFF_CAP);
  localparam logic [REG_W-1:0]  CAP_WORD = src_word_mask()
      | (REG_W'(1) << (CAP_MODE_LSB + int'(POLARITY)))
      | (REG_W'(BURST_STATIC) << CAP_BURST_BIT);

  logic [NSRC-1:0]  ev_vec, clr_bits, en_bits, stat_q, en_q;
  logic             gie_q, pend;
  logic [VEC_W-1:0] vec_q;
  logic [REG_W-1:0] stat_word, en_word;

  assign ev_vec = {ev_cmd_ready, ev_loc_change, ev_sts_valid, ev_data_avail};

  always_comb begin
    stat_word = '0;
    en_word   = '0;
    for (int i = 0; i < NSRC; i++) begin
      clr_bits[i]            = reg_wdata[src_pos(i)];
      en_bits[i]             = reg_wdata[src_pos(i)];
      stat_word[src_pos(i)]  = stat_q[i];
      en_word[src_pos(i)]    = en_q[i];
    end
    en_word[GIE_BIT] = gie_q;
  end

  evirq_status #(.N(NSRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_vec),
    .clr_we   (reg_wr && reg_addr == A_STAT),
    .clr_bits (clr_bits),
    .stat_q   (stat_q)
  );

  evirq_cfg #(.N(NSRC), .VEC_W(VEC_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .en_we    (reg_wr && reg_addr == A_EN),
    .en_bits  (en_bits),
    .gie_bit  (reg_wdata[GIE_BIT]),
    .vec_we   (reg_wr && reg_addr == A_VEC),
    .vec_bits (reg_wdata[VEC_W-1:0]),
    .en_q     (en_q),
    .gie_q    (gie_q),
    .vec_q    (vec_q)
  );

  assign pend = gie_q && |(stat_q & en_q);

  evirq_out #(.POL(POLARITY)) u_out (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend),
    .irq_o (irq_o)
  );

  assign irq_line = vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_EN:    reg_rdata <= en_word;
        A_VEC:   reg_rdata <= REG_W'(vec_q);
        A_STAT:  reg_rdata <= stat_word;
        A_CAP:   reg_rdata <= CAP_WORD;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/evirq_chk.sv
module evirq_chk
  import evirq_pkg::*;
#(
  parameter int   ADDR_W       = 12,
  parameter int   VEC_W        = 4,
  parameter pol_e POLARITY     = POL_LEVEL_HIGH,
  parameter bit   BURST_STATIC = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NSRC-1:0]   ev,
  input logic              irq_o,
  input logic [REG_W-1:0]  stat_word,
  input logic [REG_W-1:0]  en_word
);
  localparam logic [REG_W-1:0] EN_KEEP = src_word_mask() | (REG_W'(1) << GIE_BIT);
  logic [REG_W-1:0] cap_exp;
  always_comb begin
    cap_exp = src_word_mask();
    cap_exp[CAP_MODE_LSB + int'(POLARITY)] = 1'b1;
    cap_exp[CAP_BURST_BIT] = BURST_STATIC;
  end

  logic stat_wr, en_wr;
  assign stat_wr = reg_wr && reg_addr == ADDR_W'(OFF_STAT);
  assign en_wr   = reg_wr && reg_addr == ADDR_W'(OFF_EN);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int P = src_pos(i);
    a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> stat_word[P]);
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
      stat_word[P] && !(stat_wr && reg_wdata[P]) |=> stat_word[P]);
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
      stat_wr && reg_wdata[P] && !ev[i] |=> !stat_word[P]);
    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
      stat_wr && reg_wdata[P] && ev[i] |=> stat_word[P]);
  end

  a_r5_enable_write: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> en_word == ($past(reg_wdata) & EN_KEEP));

  a_r5_enable_read: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(OFF_EN) |=> (reg_rdata & ~EN_KEEP) == '0);

  a_r7_vector_read: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(OFF_VEC) |=> reg_rdata[REG_W-1:VEC_W] == '0);

  a_r8_cap_read: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(OFF_CAP) |=> reg_rdata == cap_exp);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr != ADDR_W'(OFF_EN) && reg_addr != ADDR_W'(OFF_VEC)
    && reg_addr != ADDR_W'(OFF_STAT) && reg_addr != ADDR_W'(OFF_CAP)
    |=> reg_rdata == '0);

  if (POLARITY == POL_LEVEL_HIGH) begin : g_lvl
    a_r6_irq_rise: assert property (@(posedge clk) disable iff (rst)
      en_word[GIE_BIT] && |(stat_word & en_word & src_word_mask()) |=> irq_o);
    a_r6_irq_low: assert property (@(posedge clk) disable iff (rst)
      !(en_word[GIE_BIT] && |(stat_word & en_word & src_word_mask())) |=> !irq_o);
  end
endmodule

bind evirq_ctrl evirq_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .POLARITY(POLARITY), .BURST_STATIC(BURST_STATIC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .ev        (ev_vec),
  .irq_o     (irq_o),
  .stat_word (stat_word),
  .en_word   (en_word)
);

// File: tb/tb_evirq_ctrl.sv
module tb_evirq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  evs = '0;
  logic        irq_o;
  logic [3:0]  irq_line;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  evirq_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_data_avail(evs[0]), .ev_sts_valid(evs[1]), .ev_loc_change(evs[2]),
    .ev_cmd_ready(evs[3]), .irq_o(irq_o), .irq_line(irq_line)
  );

  // {is_read, addr, wdata, expected, req}
  localparam int NV = 12;
  localparam logic [80:0] VTAB [NV] = '{
    {1'b1, 12'h014, 32'h0, 32'h0000018F, 4'd8},        // R8 cap value
    {1'b0, 12'h014, 32'hFFFFFFFF, 32'h0, 4'd8},         // R8 write ignored
    {1'b1, 12'h014, 32'h0, 32'h0000018F, 4'd8},        // R8
    {1'b1, 12'h010, 32'h0, 32'h0, 4'd1},               // R1 status
    {1'b1, 12'h008, 32'h0, 32'h0, 4'd1},               // R1 enable
    {1'b0, 12'h008, 32'hFFFFFFFF, 32'h0, 4'd5},         // R5
    {1'b1, 12'h008, 32'h0, 32'h80000087, 4'd5},        // R5 kept bits
    {1'b0, 12'h00C, 32'hFFFFFFFF, 32'h0, 4'd7},         // R7
    {1'b1, 12'h00C, 32'h0, 32'h0000000F, 4'd7},        // R7 low 4 bits
    {1'b1, 12'h020, 32'h0, 32'h0, 4'd9},               // R9 unmapped
    {1'b0, 12'h008, 32'h0, 32'h0, 4'd5},                // R5
    {1'b1, 12'h008, 32'h0, 32'h0, 4'd5}                 // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); evs = m;
    @(negedge clk); evs = '0;
  endtask

  task automatic clash(input logic [31:0] d, input logic [3:0] m);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 12'h010; reg_wdata = d; evs = m;
    @(negedge clk); reg_wr = 1'b0; evs = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq idle", {31'b0, irq_o}, 32'h0);
    check("R1 line", {28'b0, irq_line}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VTAB[k][80]) begin
        do_rd(VTAB[k][79:68], rd);
        check($sformatf("R%0d vector %0d", VTAB[k][3:0], k), rd, VTAB[k][35:4]);
      end else begin
        do_wr(VTAB[k][79:68], VTAB[k][67:36]);
      end
    end
    check("R7 irq_line", {28'b0, irq_line}, 32'h0000000F);

    // R2: latching with sources disabled
    pulse(4'b1111);
    do_rd(12'h010, rd); check("R2 all sources", rd, 32'h00000087);
    check("R6 disabled no irq", {31'b0, irq_o}, 32'h0);

    // R3: write-1-to-clear
    do_wr(12'h010, 32'h00000005);
    do_rd(12'h010, rd); check("R3 partial clear", rd, 32'h00000082);
    do_wr(12'h010, 32'hFFFFFF78);
    do_rd(12'h010, rd); check("R3 unmapped bits", rd, 32'h00000082);
    do_wr(12'h010, 32'h00000080);
    do_rd(12'h010, rd); check("R3 clear bit7", rd, 32'h00000002);

    // R4: event wins over simultaneous clear
    clash(32'h00000001, 4'b0001);
    do_rd(12'h010, rd); check("R4 set on clear", rd, 32'h00000003);
    clash(32'h00000002, 4'b0001);
    do_rd(12'h010, rd); check("R4 other bit clears", rd, 32'h00000001);
    clash(32'h00000080, 4'b1000);
    do_rd(12'h010, rd); check("R4 bit7", rd, 32'h00000081);

    // R6: gating and one-cycle output latency
    do_wr(12'h008, 32'h00000001);
    @(negedge clk);
    check("R6 no global enable", {31'b0, irq_o}, 32'h0);
    do_wr(12'h008, 32'h80000001);
    check("R6 not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R6 raised", {31'b0, irq_o}, 32'h1);
    do_wr(12'h010, 32'h00000001);
    check("R6 still high", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R6 dropped", {31'b0, irq_o}, 32'h0);
    do_wr(12'h008, 32'h80000080);
    @(negedge clk);
    check("R6 bit7 source", {31'b0, irq_o}, 32'h1);
    do_wr(12'h008, 32'h00000080);
    @(negedge clk);
    check("R6 global off", {31'b0, irq_o}, 32'h0);

    // R2 event path to output while enabled
    do_wr(12'h010, 32'hFFFFFFFF);
    do_wr(12'h008, 32'h80000004);
    pulse(4'b0100);
    check("R2 irq latency", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R2 irq from event", {31'b0, irq_o}, 32'h1);
    do_rd(12'h010, rd); check("R2 loc change bit", rd, 32'h00000004);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 line after reset", {28'b0, irq_line}, 32'h0);
    do_rd(12'h008, rd); check("R1 enable after reset", rd, 32'h0);
    do_rd(12'h010, rd); check("R1 status after reset", rd, 32'h0);
    do_rd(12'h00C, rd); check("R1 vector after reset", rd, 32'h0);

    done = 1;
    summary();
  end
endmodule